// File: doc/BRIEF.md
# UART Transmit Buffer Sequencer

This block feeds a UART transmitter one buffer at a time. A host offers a buffer with a valid/ready handshake, giving its byte count and a per-buffer "hold done until the line is clear" flag. The sequencer reads the bytes in index order through a request/acknowledge fetch port. It writes each byte into an external transmit FIFO whenever that FIFO reports space. It then raises a buffer-done event. If the hold flag is clear, the event follows the write of the final byte. If the flag is set, the event waits until the serializer signals the start of a stop bit while the FIFO is empty.

A graceful-stop command lets the buffer in flight finish and then halts the sequencer. If no buffer is in flight, the halt is immediate. Either way a stop-complete event is raised. The sequencer stays halted until a restart command arrives. Both events live in a sticky, write-one-to-clear register, and a mask selects which of them drive a single interrupt line.

Top module: `uart_txbuf_seq`

## Requirements
- R1: When a graceful stop is commanded while a buffer is in flight, the stop-complete event (event bit 1) is raised in the same cycle as that buffer's done event (event bit 0), and not earlier.
- R2: When a graceful stop is commanded while no buffer is in flight, event bit 1 reads 1 in the cycle after the command. A buffer offered in the command's cycle is not accepted (buf_ready reads 0).
- R3: For a buffer whose hold flag is 1, event bit 0 stays 0 until a clock edge samples stop_strobe=1 together with fifo_empty=1 after the last byte write. It reads 1 in the cycle after that edge.
- R4: For a buffer whose hold flag is 0, event bit 0 reads 1 in the cycle after the write of its final byte, and reads 0 during that write cycle.
- R5: While halted, buf_ready stays 0 and no FIFO write occurs. A cmd_restart pulse returns the block to accepting buffers.
- R6: Byte i of a buffer (i = 0 to length-1) is fetched at fetch_idx = i and written in increasing i order, one write per byte. fifo_wr is never 1 while fifo_full is 1.
- R7: Event bits are sticky. Writing 1 to an evt_clr bit clears that bit only. A set in the same cycle wins over a clear.
- R8: irq equals the OR of (evt AND evt_mask), updated on the same clock edge as the event bits.
- R9: A buffer of length zero raises event bit 0 in the cycle after acceptance, with no fetch and no FIFO write.
- R10: After reset, evt=0, irq=0, fifo_wr=0, fetch_req=0 and buf_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_valid | input | 1 | A buffer is offered |
| buf_len | input | LEN_W | Byte count of the offered buffer |
| buf_wfc | input | 1 | Hold done event until the line is clear |
| buf_ready | output | 1 | Offered buffer accepted this cycle when valid |
| fetch_req | output | 1 | Byte fetch request |
| fetch_idx | output | LEN_W | Index of requested byte |
| fetch_ack | input | 1 | Fetch data valid |
| fetch_data | input | DATA_W | Fetched byte |
| fifo_wr | output | 1 | Write strobe to transmit FIFO |
| fifo_data | output | DATA_W | Byte written to FIFO |
| fifo_full | input | 1 | FIFO has no space |
| fifo_empty | input | 1 | FIFO holds no byte |
| stop_strobe | input | 1 | Serializer starts a stop bit |
| cmd_gstop | input | 1 | Graceful-stop command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| evt_clr | input | 2 | Write-one-to-clear per event bit |
| evt_mask | input | 2 | Interrupt enable per event bit |
| evt | output | 2 | Event bits: [0] buffer done, [1] stop complete |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong sequencer state shows up at the ports within one cycle. A stuck halt keeps buf_ready low after restart. A premature halt drops bytes of the current buffer, so fewer fifo_wr pulses arrive than the length offered. A missed drain state moves event bit 0 to the cycle after the last write instead of after the qualifying stop strobe. A wrong byte counter shows as an out-of-order fifo_data value, or as a write count different from the length at the point where the done event appears. The sweep covers every length from 0 to 6 under both hold settings, so off-by-one errors at the first and last byte show up at once.

// File: rtl/uart_txbuf_pkg.sv
package uart_txbuf_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_XFER  = 2'd1,
    SQ_DRAIN = 2'd2,
    SQ_HALT  = 2'd3
  } sq_state_t;

  localparam int EV_N   = 2;
  localparam int EV_TXB = 0;
  localparam int EV_GSC = 1;
endpackage

// File: rtl/txbuf_bytepath.sv
module txbuf_bytepath #(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  output logic              fetch_req,
  output logic [LEN_W-1:0]  fetch_idx,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_data,
  input  logic              fifo_full,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              last_push
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic              active_q;
  logic              phase_push_q;
  logic [LEN_W-1:0]  idx_q;
  logic [LEN_W-1:0]  rem_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q     <= 1'b0;
      phase_push_q <= 1'b0;
      idx_q        <= '0;
      rem_q        <= '0;
      data_q       <= '0;
    end else if (start) begin
      active_q     <= 1'b1;
      phase_push_q <= 1'b0;
      idx_q        <= '0;
      rem_q        <= start_len;
    end else if (active_q) begin
      if (!phase_push_q) begin
        if (fetch_ack) begin
          data_q       <= fetch_data;
          phase_push_q <= 1'b1;
        end
      end else if (!fifo_full) begin
        idx_q        <= idx_q + ONE;
        rem_q        <= rem_q - ONE;
        phase_push_q <= 1'b0;
        if (rem_q == ONE) active_q <= 1'b0;
      end
    end
  end

  always_comb begin
    fetch_req = active_q && !phase_push_q;
    fetch_idx = idx_q;
    fifo_wr   = active_q && phase_push_q && !fifo_full;
    fifo_data = data_q;
    last_push = fifo_wr && (rem_q == ONE);
  end

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (rem_q != '0)); // R6
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    start |=> (fetch_req && fetch_idx == '0)); // R6
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
  import uart_txbuf_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             buf_valid,
  input  logic [LEN_W-1:0] buf_len,
  input  logic             buf_wfc,
  output logic             buf_ready,
  input  logic             cmd_gstop,
  input  logic             cmd_restart,
  input  logic             last_push,
  input  logic             stop_strobe,
  input  logic             fifo_empty,
  output logic             path_start,
  output logic             set_txb,
  output logic             set_gsc,
  output logic             halted,
  output logic             draining,
  output logic             wfc_held
);
  sq_state_t st_q, st_d;
  logic      stop_pend_q, stop_pend_d;
  logic      wfc_q;
  logic      accept, stop_req;

  always_comb begin
    buf_ready  = (st_q == SQ_IDLE) && !cmd_gstop;
    accept     = buf_valid && buf_ready;
    path_start = accept && (buf_len != '0);
    stop_req   = cmd_gstop || stop_pend_q;
    st_d       = st_q;
    set_txb    = 1'b0;
    set_gsc    = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (cmd_gstop) begin
          st_d    = SQ_HALT;
          set_gsc = 1'b1;
        end else if (accept) begin
          if (buf_len == '0) set_txb = 1'b1;
          else               st_d    = SQ_XFER;
        end
      end
      SQ_XFER: begin
        if (last_push) begin
          if (wfc_q) begin
            st_d = SQ_DRAIN;
          end else begin
            set_txb = 1'b1;
            if (stop_req) begin
              st_d    = SQ_HALT;
              set_gsc = 1'b1;
            end else begin
              st_d = SQ_IDLE;
            end
          end
        end
      end
      SQ_DRAIN: begin
        if (stop_strobe && fifo_empty) begin
          set_txb = 1'b1;
          if (stop_req) begin
            st_d    = SQ_HALT;
            set_gsc = 1'b1;
          end else begin
            st_d = SQ_IDLE;
          end
        end
      end
      default: begin
        if (cmd_gstop)        set_gsc = 1'b1;
        else if (cmd_restart) st_d    = SQ_IDLE;
      end
    endcase
    stop_pend_d = ((st_d == SQ_XFER) || (st_d == SQ_DRAIN)) && stop_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      stop_pend_q <= 1'b0;
      wfc_q       <= 1'b0;
    end else begin
      st_q        <= st_d;
      stop_pend_q <= stop_pend_d;
      if (accept) wfc_q <= buf_wfc;
    end
  end

  assign halted   = (st_q == SQ_HALT);
  assign draining = (st_q == SQ_DRAIN);
  assign wfc_held = wfc_q;

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted && !cmd_restart) |=> halted); // R5
  AST_PEND_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    stop_pend_q |-> (st_q == SQ_XFER || st_q == SQ_DRAIN)); // R1
endmodule

// File: rtl/txbuf_events.sv
module txbuf_events
  import uart_txbuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_N-1:0] set,
  input  logic [EV_N-1:0] clr,
  input  logic [EV_N-1:0] mask,
  output logic [EV_N-1:0] evt,
  output logic            irq
);
  logic [EV_N-1:0] evt_q, evt_d;

  always_comb evt_d = (evt_q & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      irq   <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq   <= |(evt_d & mask);
    end
  end

  assign evt = evt_q;

  genvar g;
  generate
    for (g = 0; g < EV_N; g++) begin : g_chk
      AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (evt_q[g] && !clr[g]) |=> evt_q[g]); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set[g] |=> evt_q[g]); // R7
    end
  endgenerate
endmodule

// File: rtl/uart_txbuf_seq.sv
module uart_txbuf_seq
  import uart_txbuf_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_valid,
  input  logic [LEN_W-1:0]  buf_len,
  input  logic              buf_wfc,
  output logic              buf_ready,
  output logic              fetch_req,
  output logic [LEN_W-1:0]  fetch_idx,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              stop_strobe,
  input  logic              cmd_gstop,
  input  logic              cmd_restart,
  input  logic [1:0]        evt_clr,
  input  logic [1:0]        evt_mask,
  output logic [1:0]        evt,
  output logic              irq
);
  logic            path_start, last_push;
  logic            set_txb, set_gsc;
  logic            halted, draining, wfc_held;
  logic [EV_N-1:0] ev_set;

  txbuf_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .buf_valid(buf_valid), .buf_len(buf_len), .buf_wfc(buf_wfc),
    .buf_ready(buf_ready),
    .cmd_gstop(cmd_gstop), .cmd_restart(cmd_restart),
    .last_push(last_push), .stop_strobe(stop_strobe), .fifo_empty(fifo_empty),
    .path_start(path_start), .set_txb(set_txb), .set_gsc(set_gsc),
    .halted(halted), .draining(draining), .wfc_held(wfc_held)
  );

  txbuf_bytepath #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rst(rst),
    .start(path_start), .start_len(buf_len),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .last_push(last_push)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXB] = set_txb;
    ev_set[EV_GSC] = set_gsc;
  end

  txbuf_events u_evt (
    .clk(clk), .rst(rst),
    .set(ev_set), .clr(evt_clr), .mask(evt_mask),
    .evt(evt), .irq(irq)
  );

  AST_NOWAIT_DONE: assert property (@(posedge clk) disable iff (rst)
    (last_push && !wfc_held) |=> evt[EV_TXB]); // R4
  AST_WAIT_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
    ($rose(evt[EV_TXB]) && $past(draining)) |-> $past(stop_strobe && fifo_empty)); // R3
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!fifo_wr && !buf_ready)); // R5
  AST_GSC_HALTS: assert property (@(posedge clk) disable iff (rst)
    $rose(evt[EV_GSC]) |-> halted); // R1
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
    (buf_valid && buf_ready && buf_len == '0) |=> (evt[EV_TXB] && !fetch_req && !fifo_wr)); // R9
endmodule

// File: tb/test_uart_txbuf_seq.sv
module test_uart_txbuf_seq;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              buf_valid = 1'b0;
  logic [LEN_W-1:0]  buf_len = '0;
  logic              buf_wfc = 1'b0;
  logic              buf_ready;
  logic              fetch_req;
  logic [LEN_W-1:0]  fetch_idx;
  logic              fetch_ack;
  logic [DATA_W-1:0] fetch_data;
  logic              fifo_wr;
  logic [DATA_W-1:0] fifo_data;
  logic              fifo_full = 1'b0;
  logic              fifo_empty = 1'b0;
  logic              stop_strobe = 1'b0;
  logic              cmd_gstop = 1'b0;
  logic              cmd_restart = 1'b0;
  logic [1:0]        evt_clr = 2'b00;
  logic [1:0]        evt_mask = 2'b00;
  logic [1:0]        evt;
  logic              irq;

  int errors = 0;
  int checks = 0;
  int npush  = 0;
  logic [7:0] base = 8'd0;
  bit finished = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  assign fetch_ack  = fetch_req;
  assign fetch_data = 8'(base + 8'(fetch_idx) * 8'd3);

  uart_txbuf_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) i_uart_txbuf_seq (
    .clk(clk), .rst(rst),
    .buf_valid(buf_valid), .buf_len(buf_len), .buf_wfc(buf_wfc), .buf_ready(buf_ready),
    .fetch_req(fetch_req), .fetch_idx(fetch_idx), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .stop_strobe(stop_strobe), .cmd_gstop(cmd_gstop), .cmd_restart(cmd_restart),
    .evt_clr(evt_clr), .evt_mask(evt_mask), .evt(evt), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6: every write in order, never while full
  always @(negedge clk) begin
    if (!rst && fifo_wr) begin
      chk(!fifo_full, "R6 write while full", 1, 0);
      chk(fifo_data == 8'(base + 8'(npush) * 8'd3), "R6 byte order",
          int'(fifo_data), int'(8'(base + 8'(npush) * 8'd3)));
      npush++;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_evt();
    tick(); evt_clr = 2'b11;
    tick(); evt_clr = 2'b00;
  endtask

  task automatic submit(input int len, input bit wfc);
    bit taken = 1'b0;
    tick();
    buf_len = LEN_W'(len); buf_wfc = wfc; buf_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      if (buf_ready) begin
        tick();
        buf_valid = 1'b0;
        taken = 1'b1;
      end
    end
  endtask

  task automatic wait_push(input int n);
    while (npush < n) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic strobe_pulse();
    stop_strobe = 1'b1;
    @(negedge clk);
    chk(evt[0] == 1'b0 || fifo_empty, "R3 no done before qualifying edge", int'(evt[0]), 0);
    tick();
    stop_strobe = 1'b0;
  endtask

  task automatic run_buffer(input int len, input bit wfc);
    clear_evt();
    npush = 0;
    base = 8'(len * 16 + (wfc ? 5 : 0));
    fifo_empty = 1'b0;
    submit(len, wfc);
    if (len == 3) begin
      fifo_full = 1'b1;
      repeat (6) tick();
      chk(npush == 0, "R6 stall while full", npush, 0);
      fifo_full = 1'b0;
    end
    if (len == 0) begin
      @(negedge clk);
      chk(evt[0] == 1'b1, "R9 zero length done", int'(evt[0]), 1);
      repeat (4) @(negedge clk);
      chk(npush == 0, "R9 zero length writes", npush, 0);
    end else begin
      wait_push(len);
      chk(evt[0] == 1'b0, wfc ? "R3 done not at last write" : "R4 done not during last write",
          int'(evt[0]), 0);
      if (!wfc) begin
        @(negedge clk);
        chk(evt[0] == 1'b1, "R4 done after last write", int'(evt[0]), 1);
      end else begin
        repeat (3) @(negedge clk);
        chk(evt[0] == 1'b0, "R3 waits for line clear", int'(evt[0]), 0);
        tick();
        strobe_pulse();
        @(negedge clk);
        chk(evt[0] == 1'b0, "R3 strobe with FIFO busy ignored", int'(evt[0]), 0);
        tick();
        fifo_empty = 1'b1;
        strobe_pulse();
        @(negedge clk);
        chk(evt[0] == 1'b1, "R3 done after strobe on empty", int'(evt[0]), 1);
      end
      repeat (3) @(negedge clk);
      chk(npush == len, "R6 write count", npush, len);
    end
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk(evt == 2'b00, "R10 evt reset", int'(evt), 0);
    chk(irq == 1'b0, "R10 irq reset", int'(irq), 0);
    chk(!fifo_wr && !fetch_req, "R10 idle outputs", int'(fifo_wr), 0);
    chk(buf_ready == 1'b1, "R10 ready reset", int'(buf_ready), 1);

    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 7; l++)
        run_buffer(l, bit'(w));

    // R2 / R5: stop while idle, then restart
    clear_evt();
    npush = 0; base = 8'd200; fifo_empty = 1'b0;
    tick();
    cmd_gstop = 1'b1; buf_valid = 1'b1; buf_len = 4'd2; buf_wfc = 1'b0;
    @(negedge clk);
    chk(buf_ready == 1'b0, "R2 no accept with stop", int'(buf_ready), 0);
    tick();
    cmd_gstop = 1'b0;
    @(negedge clk);
    chk(evt[1] == 1'b1, "R2 immediate stop complete", int'(evt[1]), 1);
    repeat (10) @(negedge clk);
    chk(buf_ready == 1'b0, "R5 halted not ready", int'(buf_ready), 0);
    chk(npush == 0, "R5 halted no writes", npush, 0);
    tick(); cmd_restart = 1'b1;
    tick(); cmd_restart = 1'b0;
    wait_push(2);
    buf_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(evt[0] == 1'b1, "R5 resumes after restart", int'(evt[0]), 1);

    // R1: stop with buffer in flight
    clear_evt();
    npush = 0; base = 8'd90; fifo_empty = 1'b0;
    submit(5, 1'b1);
    wait_push(2);
    tick(); cmd_gstop = 1'b1;
    tick(); cmd_gstop = 1'b0;
    wait_push(5);
    repeat (3) @(negedge clk);
    chk(evt == 2'b00, "R1 no complete before buffer done", int'(evt), 0);
    tick(); fifo_empty = 1'b1;
    strobe_pulse();
    @(negedge clk);
    chk(evt == 2'b11, "R1 complete with buffer done", int'(evt), 3);
    chk(npush == 5, "R1 buffer finished", npush, 5);

    // R5: halted after in-flight stop
    npush = 0; base = 8'd60; fifo_empty = 1'b0;
    tick(); buf_valid = 1'b1; buf_len = 4'd1; buf_wfc = 1'b0;
    repeat (8) @(negedge clk);
    chk(npush == 0 && !buf_ready, "R5 still halted", npush, 0);
    tick(); cmd_restart = 1'b1;
    tick(); cmd_restart = 1'b0;
    wait_push(1);
    buf_valid = 1'b0;
    chk(npush == 1, "R5 restart serves buffer", npush, 1);

    // R7 / R8: clear and mask
    repeat (3) tick();
    evt_mask = 2'b10;
    tick();
    @(negedge clk);
    chk(evt == 2'b11, "R7 both sticky", int'(evt), 3);
    chk(irq == 1'b1, "R8 irq from stop event", int'(irq), 1);
    tick(); evt_clr = 2'b10;
    tick(); evt_clr = 2'b00;
    @(negedge clk);
    chk(evt == 2'b01, "R7 clear one bit only", int'(evt), 1);
    chk(irq == 1'b0, "R8 irq masked off", int'(irq), 0);
    tick(); evt_mask = 2'b01;
    tick();
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq from done event", int'(irq), 1);
    tick(); cmd_gstop = 1'b1; evt_clr = 2'b10;
    tick(); cmd_gstop = 1'b0; evt_clr = 2'b00;
    @(negedge clk);
    chk(evt[1] == 1'b1, "R7 set wins over clear", int'(evt[1]), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule